// File: doc/BRIEF.md
# Sparse Column Multiply-Accumulate Engine

This block is one processing element of a sparse matrix-vector multiplier. The weight matrix is held column-compressed: a pointer buffer gives, for each column, where its packed entries begin in a weight buffer and where the next column begins. Each packed entry carries a signed 12-bit weight and a 4-bit row delta. The engine takes one activation per column, walks that column's entries, and rebuilds each entry's local row from the running sum of deltas. It multiplies the activation by the weight and adds the product into a local partial-sum buffer at that row. Matrix rows are interleaved across processing elements, so the local row counts only the rows owned by this element.

Both the pointer and weight buffers have two halves. A run reads from the half chosen at its start, and the host may write the other half during the run. A zero-weight entry with the largest delta bridges row gaps that a single delta cannot span. Products are kept at full precision and then shifted right by a per-run amount before they reach the 16-bit partial sums. This lets each layer choose its own fixed-point alignment.

Top module: `sparse_col_mac`

## Requirements
- R1: A weight entry holds the row delta in bits [15:12] and a two's-complement weight in bits [11:0]. Within a column the first entry lands on row equal to its delta, and each later entry lands on the previous entry's row plus delta plus one.
- R2: Column j covers the weight-buffer addresses from pointer word j up to, but not including, pointer word j+1. Only the low address bits of a pointer word are used.
- R3: An entry with a zero weight advances the row position like any other entry and leaves every partial sum unchanged.
- R4: Each product of the 16-bit signed activation and the 12-bit signed weight is formed at full precision. It is then arithmetically shifted right by the run's shift amount and added to the partial sum, with the result saturated to the range -32768..32767.
- R5: An entry whose row is at or beyond the number of local rows is discarded and changes no partial sum.
- R6: Reset, and every accepted start, clear all partial sums to zero. The read port returns the stored sum of the addressed row in the same cycle.
- R7: The engine takes exactly one activation per column, in column order, through a valid/ready handshake. Ready is high only while the engine is waiting for the next column's activation.
- R8: A column whose end pointer is not above its start pointer is skipped in a single cycle after its activation is taken. A run of N such columns, with the activation always valid, keeps busy high for exactly 2N+1 cycles.
- R9: Done is a one-cycle pulse, raised once busy has dropped after the last entry has been accumulated. A run with a column count of zero gives done after one busy cycle and leaves all sums cleared.
- R10: A run reads only the buffer half selected at its start. Host writes to the other half during the run do not change its results.
- R11: A start that arrives while the engine is busy is ignored, together with the bank, column count and shift presented with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_wr_en | input | 1 | Pointer buffer write strobe |
| ptr_wr_bank | input | 1 | Pointer buffer half to write |
| ptr_wr_addr | input | log2(BANK_DEPTH) | Pointer word address |
| ptr_wr_data | input | 16 | Pointer word |
| wgt_wr_en | input | 1 | Weight buffer write strobe |
| wgt_wr_bank | input | 1 | Weight buffer half to write |
| wgt_wr_addr | input | log2(BANK_DEPTH) | Weight entry address |
| wgt_wr_data | input | 16 | Packed entry: delta [15:12], weight [11:0] |
| start | input | 1 | Begin a run (ignored while busy) |
| run_bank | input | 1 | Buffer half the run reads |
| num_cols | input | log2(BANK_DEPTH) | Number of columns in the run |
| shift_amt | input | SHIFT_W | Right shift applied to each product |
| act_valid | input | 1 | Activation offered |
| act_data | input | 16 | Signed activation for the current column |
| act_ready | output | 1 | Engine takes the activation this cycle if valid |
| psum_rd_addr | input | log2(LOCAL_ROWS) | Partial-sum row to read |
| psum_rd_data | output | 16 | Signed partial sum of the addressed row |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the engine with 64 words per buffer half and 16 local rows. The half depth keeps a full random matrix small, and with only 16 local rows, random deltas and bridging entries often push rows past the local range, so discarded entries show up in most random runs. Full-scale activations against extreme weights reach both saturation limits with a zero shift. Random shifts up to six exercise rounding toward minus infinity on negative products. Runs of empty columns expose the per-column cycle cost directly at the busy output.

// File: rtl/spc_pkg.sv
// Shared widths and types for the sparse column multiply-accumulate engine.
// Assumes 16-bit packed entries: 4-bit row delta over a 12-bit signed weight.
package spc_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int ENTRY_W = 16;
    localparam int DELTA_W = 4;
    localparam int WGT_W   = 12;
    localparam int ACT_W   = 16;
    localparam int PSUM_W  = 16;
    localparam int PROD_W  = ACT_W + WGT_W;

    typedef struct packed {
        logic [DELTA_W-1:0]      delta;
        logic signed [WGT_W-1:0] weight;
    } spc_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_COLSET,
        S_STREAM,
        S_DRAIN
    } spc_state_e;
endpackage

// File: rtl/spc_pingpong_ram.sv
// Two-half buffer with one host write port and RD_PORTS registered read ports.
// Assumes the host keeps off the half that a run is reading; no collision logic.
module spc_pingpong_ram #(
    parameter int WIDTH    = 16,
    parameter int DEPTH    = 512,
    parameter int RD_PORTS = 1,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                               clk,
    input  logic                               wr_en,
    input  logic                               wr_bank,
    input  logic [AW-1:0]                      wr_addr,
    input  logic [WIDTH-1:0]                   wr_data,
    input  logic                               rd_en,
    input  logic                               rd_bank,
    input  logic [RD_PORTS-1:0][AW-1:0]        rd_addr,
    output logic [RD_PORTS-1:0][WIDTH-1:0]     rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [WIDTH-1:0] mem [2*DEPTH];

    // Host write into either half.
    always_ff @(posedge clk) begin
        if (wr_en) mem[{wr_bank, wr_addr}] <= wr_data;
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        // Registered read of the selected half, one cycle latency.
        always_ff @(posedge clk) begin
            if (rd_en) rd_data[p] <= mem[{rd_bank, rd_addr[p]}];
        end
    end
endmodule

// File: rtl/spc_entry_mac.sv
// Decodes one packed entry per cycle: rebuilds the local row from the running
// delta sum and forms the shifted full-precision product.
// Assumes col_start and in_valid never coincide (the controller guarantees it).
module spc_entry_mac
    import spc_pkg::*;
#(
    parameter int ROW_W   = 14,
    parameter int SHIFT_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     col_start,
    input  logic                     in_valid,
    input  logic [ENTRY_W-1:0]       in_entry,
    input  logic signed [ACT_W-1:0]  act,
    input  logic [SHIFT_W-1:0]       shift,
    output logic                     out_valid,
    output logic [ROW_W-1:0]         out_row,
    output logic signed [PROD_W-1:0] out_val
);
    timeunit 1ns;
    timeprecision 1ps;

    spc_entry_t               ent;
    logic [ROW_W-1:0]         row_acc;
    logic [ROW_W-1:0]         row_next;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] prod_sh;

    // Unpack, advance the row and scale the product.
    always_comb begin
        ent      = spc_entry_t'(in_entry);
        row_next = row_acc + ROW_W'(ent.delta) + ROW_W'(1);
        prod     = act * ent.weight;
        prod_sh  = prod >>> shift;
    end

    // Running row position, restarted at minus one for every column.
    always_ff @(posedge clk) begin
        if (!rst_n)          row_acc <= '1;
        else if (col_start)  row_acc <= '1;
        else if (in_valid)   row_acc <= row_next;
    end

    // Result register feeding the partial-sum stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_row   <= '0;
            out_val   <= '0;
        end else begin
            out_valid <= in_valid;
            out_row   <= row_next;
            out_val   <= prod_sh;
        end
    end

    // R3: rows inside one column only move upward
    a_r3_row_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !col_start) |=> ((row_acc > $past(row_acc)) || ($past(row_acc) == '1)));
endmodule

// File: rtl/spc_psum_bank.sv
// Local partial-sum store: single-cycle saturating accumulate, bulk clear,
// asynchronous read. Assumes accumulate rows may exceed the local range.
module spc_psum_bank
    import spc_pkg::*;
#(
    parameter int LOCAL_ROWS = 64,
    parameter int ROW_W      = 14,
    localparam int ROW_AW    = $clog2(LOCAL_ROWS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     acc_valid,
    input  logic [ROW_W-1:0]         acc_row,
    input  logic signed [PROD_W-1:0] acc_val,
    input  logic [ROW_AW-1:0]        rd_addr,
    output logic [PSUM_W-1:0]        rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic signed [PROD_W:0] MAX_V = (PROD_W+1)'(32767);
    localparam logic signed [PROD_W:0] MIN_V = -(PROD_W+1)'(32768);

    logic signed [PSUM_W-1:0]      psum_q [LOCAL_ROWS];
    logic                          in_range;
    logic [ROW_AW-1:0]             idx;
    logic signed [PROD_W:0]        sum;
    logic signed [PSUM_W-1:0]      sat;
    logic [LOCAL_ROWS*PSUM_W-1:0]  flat;

    // Range check and saturating add for the addressed row.
    always_comb begin
        in_range = (acc_row < ROW_W'(LOCAL_ROWS));
        idx      = acc_row[ROW_AW-1:0];
        sum      = (PROD_W+1)'(psum_q[idx]) + (PROD_W+1)'(acc_val);
        if (sum > MAX_V)      sat = 16'sh7fff;
        else if (sum < MIN_V) sat = 16'sh8000;
        else                  sat = sum[PSUM_W-1:0];
    end

    // Partial-sum storage update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int r = 0; r < LOCAL_ROWS; r++) psum_q[r] <= '0;
        end else if (acc_valid && in_range) begin
            psum_q[idx] <= sat;
        end
    end

    assign rd_data = psum_q[rd_addr];

    for (genvar r = 0; r < LOCAL_ROWS; r++) begin : g_flat
        assign flat[r*PSUM_W +: PSUM_W] = psum_q[r];
    end

    // R5: an out-of-range row leaves the whole store untouched
    a_r5_drop_far_row: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !in_range && !clear) |=> $stable(flat));

    // R6: a clear empties every row
    a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (flat == '0));
endmodule

// File: rtl/sparse_col_mac.sv
// Sparse column multiply-accumulate processing element. Per column it takes one
// activation, reads the column's two pointer words, streams the column's entries
// and accumulates activation x weight into local partial sums.
// Assumes the host writes only the half not selected by the running job.
module sparse_col_mac
    import spc_pkg::*;
#(
    parameter int BANK_DEPTH = 512,
    parameter int LOCAL_ROWS = 64,
    parameter int SHIFT_W    = 4,
    localparam int AW        = $clog2(BANK_DEPTH),
    localparam int ROW_AW    = $clog2(LOCAL_ROWS),
    localparam int ROW_W     = AW + DELTA_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ptr_wr_en,
    input  logic                ptr_wr_bank,
    input  logic [AW-1:0]       ptr_wr_addr,
    input  logic [15:0]         ptr_wr_data,
    input  logic                wgt_wr_en,
    input  logic                wgt_wr_bank,
    input  logic [AW-1:0]       wgt_wr_addr,
    input  logic [15:0]         wgt_wr_data,
    input  logic                start,
    input  logic                run_bank,
    input  logic [AW-1:0]       num_cols,
    input  logic [SHIFT_W-1:0]  shift_amt,
    input  logic                act_valid,
    input  logic [15:0]         act_data,
    output logic                act_ready,
    input  logic [ROW_AW-1:0]   psum_rd_addr,
    output logic [15:0]         psum_rd_data,
    output logic                busy,
    output logic                done
);
    timeunit 1ns;
    timeprecision 1ps;

    spc_state_e               state_q;
    logic [AW-1:0]            col_q;
    logic [AW-1:0]            ncols_q;
    logic [AW-1:0]            cur_q;
    logic [AW-1:0]            last_q;
    logic                     bank_q;
    logic [SHIFT_W-1:0]       shift_q;
    logic signed [ACT_W-1:0]  act_q;
    logic                     rd_valid_q;
    logic                     done_q;

    logic                     ptr_rd_en;
    logic [1:0][AW-1:0]       ptr_rd_addr;
    logic [1:0][15:0]         ptr_rd_data;
    logic [AW-1:0]            ptr_lo;
    logic [AW-1:0]            ptr_hi;
    logic                     wgt_rd_en;
    logic [0:0][AW-1:0]       wgt_rd_addr;
    logic [0:0][15:0]         wgt_rd_data;
    logic                     last_col;
    logic                     accept_start;

    logic                     mac_valid;
    logic [ROW_W-1:0]         mac_row;
    logic signed [PROD_W-1:0] mac_val;

    // Read requests and handshake derived from the controller state.
    always_comb begin
        accept_start   = (state_q == S_IDLE) && start;
        act_ready      = (state_q == S_FETCH);
        ptr_rd_en      = (state_q == S_FETCH) && act_valid;
        ptr_rd_addr[0] = col_q;
        ptr_rd_addr[1] = col_q + AW'(1);
        ptr_lo         = ptr_rd_data[0][AW-1:0];
        ptr_hi         = ptr_rd_data[1][AW-1:0];
        wgt_rd_en      = (state_q == S_STREAM);
        wgt_rd_addr[0] = cur_q;
        last_col       = ((col_q + AW'(1)) == ncols_q);
    end

    // Column walk controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            col_q      <= '0;
            ncols_q    <= '0;
            cur_q      <= '0;
            last_q     <= '0;
            bank_q     <= 1'b0;
            shift_q    <= '0;
            act_q      <= '0;
            rd_valid_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q     <= 1'b0;
            rd_valid_q <= wgt_rd_en;
            case (state_q)
                S_IDLE: if (start) begin
                    bank_q  <= run_bank;
                    shift_q <= shift_amt;
                    ncols_q <= num_cols;
                    col_q   <= '0;
                    state_q <= (num_cols == '0) ? S_DRAIN : S_FETCH;
                end
                S_FETCH: if (act_valid) begin
                    act_q   <= act_data;
                    state_q <= S_COLSET;
                end
                S_COLSET: begin
                    if (ptr_hi > ptr_lo) begin
                        cur_q   <= ptr_lo;
                        last_q  <= ptr_hi;
                        state_q <= S_STREAM;
                    end else if (last_col) begin
                        state_q <= S_DRAIN;
                    end else begin
                        col_q   <= col_q + AW'(1);
                        state_q <= S_FETCH;
                    end
                end
                S_STREAM: begin
                    cur_q <= cur_q + AW'(1);
                    if ((cur_q + AW'(1)) == last_q) begin
                        if (last_col) begin
                            state_q <= S_DRAIN;
                        end else begin
                            col_q   <= col_q + AW'(1);
                            state_q <= S_FETCH;
                        end
                    end
                end
                S_DRAIN: if (!rd_valid_q && !mac_valid) begin
                    done_q  <= 1'b1;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy = (state_q != S_IDLE);
    assign done = done_q;

    spc_pingpong_ram #(.WIDTH(16), .DEPTH(BANK_DEPTH), .RD_PORTS(2)) u_ptr_buf (
        .clk     (clk),
        .wr_en   (ptr_wr_en),
        .wr_bank (ptr_wr_bank),
        .wr_addr (ptr_wr_addr),
        .wr_data (ptr_wr_data),
        .rd_en   (ptr_rd_en),
        .rd_bank (bank_q),
        .rd_addr (ptr_rd_addr),
        .rd_data (ptr_rd_data)
    );

    spc_pingpong_ram #(.WIDTH(ENTRY_W), .DEPTH(BANK_DEPTH), .RD_PORTS(1)) u_wgt_buf (
        .clk     (clk),
        .wr_en   (wgt_wr_en),
        .wr_bank (wgt_wr_bank),
        .wr_addr (wgt_wr_addr),
        .wr_data (wgt_wr_data),
        .rd_en   (wgt_rd_en),
        .rd_bank (bank_q),
        .rd_addr (wgt_rd_addr),
        .rd_data (wgt_rd_data)
    );

    spc_entry_mac #(.ROW_W(ROW_W), .SHIFT_W(SHIFT_W)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_start (state_q == S_COLSET),
        .in_valid  (rd_valid_q),
        .in_entry  (wgt_rd_data[0]),
        .act       (act_q),
        .shift     (shift_q),
        .out_valid (mac_valid),
        .out_row   (mac_row),
        .out_val   (mac_val)
    );

    spc_psum_bank #(.LOCAL_ROWS(LOCAL_ROWS), .ROW_W(ROW_W)) u_psum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept_start),
        .acc_valid (mac_valid),
        .acc_row   (mac_row),
        .acc_val   (mac_val),
        .rd_addr   (psum_rd_addr),
        .rd_data   (psum_rd_data)
    );

    // R1: the row restart never lands while an entry is still in decode
    a_r1_restart_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COLSET) |-> !rd_valid_q);

    // R9: done lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done only with the engine idle and the pipeline empty
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mac_valid));

    // R11: run settings stay fixed while a run is in progress
    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(bank_q) && $stable(shift_q) && $stable(ncols_q)));
endmodule

// File: tb/sim_sparse_col_mac.sv
// Self-checking bench: directed corner cases plus seeded random matrices,
// compared with a behavioural model of the column walk.
module sim_sparse_col_mac;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 64;
    localparam int ROWS  = 16;
    localparam int AW    = 6;
    localparam int RAW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ptr_wr_en = 1'b0, ptr_wr_bank = 1'b0;
    logic [AW-1:0] ptr_wr_addr = '0;
    logic [15:0] ptr_wr_data = '0;
    logic wgt_wr_en = 1'b0, wgt_wr_bank = 1'b0;
    logic [AW-1:0] wgt_wr_addr = '0;
    logic [15:0] wgt_wr_data = '0;
    logic start = 1'b0, run_bank = 1'b0;
    logic [AW-1:0] num_cols = '0;
    logic [3:0] shift_amt = '0;
    logic act_valid = 1'b0;
    logic [15:0] act_data = '0;
    logic act_ready;
    logic [RAW-1:0] psum_rd_addr = '0;
    logic [15:0] psum_rd_data;
    logic busy, done;

    int checks = 0;
    int fails  = 0;
    int ptr_m [2][DEPTH];
    int wgt_m [2][DEPTH];
    int acts  [DEPTH];
    int expv  [ROWS];
    int busy_cnt;

    always #2.5 clk = ~clk;

    sparse_col_mac #(.BANK_DEPTH(DEPTH), .LOCAL_ROWS(ROWS), .SHIFT_W(4)) u0 (
        .clk, .rst_n, .ptr_wr_en, .ptr_wr_bank, .ptr_wr_addr, .ptr_wr_data,
        .wgt_wr_en, .wgt_wr_bank, .wgt_wr_addr, .wgt_wr_data, .start, .run_bank,
        .num_cols, .shift_amt, .act_valid, .act_data, .act_ready, .psum_rd_addr,
        .psum_rd_data, .busy, .done
    );

    task automatic chk(bit ok, string req, int act, int exp_v, string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    function automatic int ent(int d, int w);
        return ((d & 15) << 12) | (w & 12'hfff);
    endfunction

    // Behavioural model of one run over bank b.
    function automatic void model(int b, int nc, int sh);
        for (int r = 0; r < ROWS; r++) expv[r] = 0;
        for (int j = 0; j < nc; j++) begin
            int row = -1;
            for (int k = ptr_m[b][j]; k < ptr_m[b][j+1]; k++) begin
                int e = wgt_m[b][k];
                int d = (e >> 12) & 15;
                int w = e & 12'hfff;
                if (w >= 2048) w -= 4096;
                row += d + 1;
                if (row < ROWS) begin
                    int p = (acts[j] * w) >>> sh;
                    int s = expv[row] + p;
                    if (s > 32767) s = 32767;
                    if (s < -32768) s = -32768;
                    expv[row] = s;
                end
            end
        end
    endfunction

    task automatic wr_ptr(int b, int a, int d);
        @(negedge clk);
        ptr_wr_en = 1'b1; ptr_wr_bank = b[0]; ptr_wr_addr = a[AW-1:0]; ptr_wr_data = d[15:0];
        @(posedge clk); #1 ptr_wr_en = 1'b0;
    endtask

    task automatic wr_wgt(int b, int a, int d);
        @(negedge clk);
        wgt_wr_en = 1'b1; wgt_wr_bank = b[0]; wgt_wr_addr = a[AW-1:0]; wgt_wr_data = d[15:0];
        @(posedge clk); #1 wgt_wr_en = 1'b0;
    endtask

    task automatic load_bank(int b, int nc);
        for (int j = 0; j <= nc; j++) wr_ptr(b, j, ptr_m[b][j]);
        for (int k = 0; k < ptr_m[b][nc]; k++) wr_wgt(b, k, wgt_m[b][k]);
    endtask

    function automatic void gen_bank(int b, int nc);
        int total = 0;
        ptr_m[b][0] = 0;
        for (int j = 0; j < nc; j++) begin
            int n = ($urandom % 4 == 0) ? 0 : int'($urandom % 5) + 1;
            if (total + n > DEPTH - 1) n = 0;
            for (int k = 0; k < n; k++) begin
                if ($urandom % 5 == 0) wgt_m[b][total+k] = ent(15, 0);
                else wgt_m[b][total+k] = ent(int'($urandom % 6), int'($urandom % 4096));
            end
            total += n;
            ptr_m[b][j+1] = total;
        end
    endfunction

    function automatic void gen_acts(int nc, bit big);
        for (int j = 0; j < nc; j++) begin
            int v = int'($urandom % 65536) - 32768;
            acts[j] = big ? v : (v % 200);
        end
    endfunction

    // Runs one job; restart injects a second start mid-run with other settings.
    task automatic run(int b, int nc, int sh, bit stall, bit restart);
        int idx = 0;
        int it = 0;
        bit seen = 1'b0;
        bit taken;
        busy_cnt = 0;
        @(negedge clk);
        act_data = acts[0][15:0]; act_valid = 1'b1;
        run_bank = b[0]; num_cols = nc[AW-1:0]; shift_amt = sh[3:0]; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        while (!seen && it < 5000) begin
            @(negedge clk);
            if (done) seen = 1'b1;
            else if (busy) busy_cnt++;
            taken = act_ready && act_valid;
            @(posedge clk); #1;
            if (taken) begin
                idx++;
                act_data = acts[idx % DEPTH][15:0];
            end
            if (restart && it == 3) begin
                start = 1'b1; run_bank = ~b[0]; num_cols = 6'd1; shift_amt = 4'd9;
            end else begin
                start = 1'b0;
            end
            act_valid = stall ? ($urandom % 3 != 0) : 1'b1;
            it++;
        end
        start = 1'b0;
        act_valid = 1'b0;
        chk(seen, "R9", int'(seen), 1, "done pulse seen");
    endtask

    task automatic check_sums(string req);
        for (int r = 0; r < ROWS; r++) begin
            psum_rd_addr = r[RAW-1:0];
            #1;
            chk($signed(psum_rd_data) == expv[r], req, int'($signed(psum_rd_data)), expv[r],
                $sformatf("row %0d sum", r));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected finish");
        fails++; checks++;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        chk(busy == 1'b0 && done == 1'b0 && act_ready == 1'b0, "R6", int'(busy), 0, "idle after reset");
        for (int r = 0; r < ROWS; r++) expv[r] = 0;
        check_sums("R6");

        // R1 R2 R3: deltas, an empty column, a zero-weight bridge entry
        ptr_m[0][0] = 0; ptr_m[0][1] = 2; ptr_m[0][2] = 2; ptr_m[0][3] = 4;
        wgt_m[0][0] = ent(2, 5); wgt_m[0][1] = ent(0, -3);
        wgt_m[0][2] = ent(3, 0); wgt_m[0][3] = ent(0, 7);
        acts[0] = 10; acts[1] = 20; acts[2] = -4;
        load_bank(0, 3);
        run(0, 3, 0, 1'b0, 1'b0);
        model(0, 3, 0);
        chk(expv[2] == 50 && expv[3] == -30 && expv[4] == -28, "R1", expv[4], -28, "model sanity");
        check_sums("R1");

        // R5: bridge past the local range, a far entry must be dropped
        ptr_m[1][0] = 0; ptr_m[1][1] = 3; ptr_m[1][2] = 5;
        wgt_m[1][0] = ent(14, 3); wgt_m[1][1] = ent(0, 11); wgt_m[1][2] = ent(3, 99);
        wgt_m[1][3] = ent(15, 0); wgt_m[1][4] = ent(0, -50);
        acts[0] = 7; acts[1] = 9;
        load_bank(1, 2);
        run(1, 2, 0, 1'b0, 1'b0);
        model(1, 2, 0);
        check_sums("R5");

        // R4: saturation at both limits
        ptr_m[0][0] = 0; ptr_m[0][1] = 2; ptr_m[0][2] = 4;
        wgt_m[0][0] = ent(0, 2047); wgt_m[0][1] = ent(0, -2048);
        wgt_m[0][2] = ent(0, 2047); wgt_m[0][3] = ent(0, -2048);
        acts[0] = 32767; acts[1] = 32767;
        load_bank(0, 2);
        run(0, 2, 0, 1'b0, 1'b0);
        model(0, 2, 0);
        chk(expv[0] == 32767 && expv[1] == -32768, "R4", expv[1], -32768, "model limits");
        check_sums("R4");

        // R8: five empty columns cost two cycles each plus one drain cycle
        for (int j = 0; j <= 5; j++) ptr_m[1][j] = 4;
        load_bank(1, 5);
        gen_acts(5, 1'b0);
        run(1, 5, 0, 1'b0, 1'b0);
        chk(busy_cnt == 11, "R8", busy_cnt, 11, "busy cycles for empty columns");

        // R9: zero columns clears sums and finishes after one busy cycle
        run(0, 0, 0, 1'b0, 1'b0);
        chk(busy_cnt == 1, "R9", busy_cnt, 1, "busy cycles for zero columns");
        for (int r = 0; r < ROWS; r++) expv[r] = 0;
        check_sums("R9");

        // R11: second start mid-run is ignored
        gen_bank(0, 10);
        gen_acts(10, 1'b0);
        load_bank(0, 10);
        run(0, 10, 2, 1'b0, 1'b1);
        model(0, 10, 2);
        check_sums("R11");

        // R10: run on bank 1 while the host rewrites bank 0
        gen_bank(1, 8);
        gen_acts(8, 1'b0);
        load_bank(1, 8);
        gen_bank(0, 9);
        fork
            run(1, 8, 1, 1'b1, 1'b0);
            load_bank(0, 9);
        join
        model(1, 8, 1);
        check_sums("R10");
        run(0, 9, 1, 1'b0, 1'b0);
        model(0, 9, 1);
        check_sums("R10");

        // R4 R7: random matrices, activations, shifts and handshake stalls
        for (int t = 0; t < 20; t++) begin
            int b  = int'($urandom % 2);
            int nc = int'($urandom % 12) + 1;
            int sh = int'($urandom % 7);
            gen_bank(b, nc);
            gen_acts(nc, ($urandom % 2) == 1);
            load_bank(b, nc);
            run(b, nc, sh, ($urandom % 2) == 1, 1'b0);
            model(b, nc, sh);
            check_sums((t % 2 == 0) ? "R7" : "R4");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule